// File: doc/BRIEF.md
# Level-Masked Interrupt Acknowledge Controller

This block sits between a group of peripheral interrupt lines and a processor. Each source line is given a priority level and a source mask bit through per-source configuration registers. A source is eligible when it is requesting, unmasked and ranked above a running "current" level mask. The controller always knows which eligible source wins and shows that winner's level to the processor on a plain output.

The processor and software talk to the block through one command/response register channel. A hardware acknowledge read returns the winner's vector. In the same cycle it moves the current mask into a "saved" mask and raises the current mask to the winner's level, so requests at that level or below are held back until software lowers the mask again. Software can read and write both masks and can restore the current mask from the saved one with a single write. A software acknowledge read gives the vector of any pending eligible request without changing either mask, so a handler can pick up more work before it returns.

Both channels use valid/ready handshakes. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. Its response appears one cycle later and is held, unchanged, until `rsp_ready` is seen high. While a response is waiting and `rsp_ready` is low, `cmd_ready` stays low. The request lines are level-sensitive, and the block keeps no latched pending state.

Top module: `intc_lvl_ack`

## Requirements
- R1: A hardware acknowledge read (address 3) with an eligible request returns vector VEC_BASE (default 64) plus the winning source index.
- R2: A hardware acknowledge that finds a winner copies the current mask into the saved mask.
- R3: The same hardware acknowledge sets the current mask to the winner's level.
- R4: A source is eligible only if its request is high, its mask bit (config bit 3) is 0, its level (config bits 2:0) is nonzero, and either its level is strictly above the current mask or its level is 7.
- R5: Among eligible sources the highest level wins. When levels are equal, the lowest source index wins.
- R6: A hardware acknowledge with no eligible request returns SPUR_VEC (default 24) and leaves both masks unchanged.
- R7: A software acknowledge read (address 4) returns the winner's vector, or 0 if nothing is eligible, and never changes either mask.
- R8: Address 0 (current mask) and address 1 (saved mask) are readable and writable with any 3-bit value. A write to address 2 copies the saved mask into the current mask.
- R9: Dropping a request line removes that source from arbitration at once. Nothing of it remains pending.
- R10: A response is held stable with `rsp_valid` high while `rsp_ready` is low, and no command is accepted meanwhile. A write's response data is the written byte.
- R11: After reset both masks are 0, every source reads back 8 (masked, level 0), and `irq_level` is 0.
- R12: `irq_level` shows the winner's level, or 0 when nothing is eligible.
- R13: Source i is configured at address 16+i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| irq_req | input | NSRC | Level-sensitive request lines, one per source |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | ADDRW | Register address; top bit set selects a source config |
| cmd_wdata | input | DW | Write data |
| rsp_valid | output | 1 | Response held for the requester |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_data | output | DW | Read data, vector, or echoed write data |
| irq_level | output | 3 | Level of the current winner, 0 if none |

## Verification
Bad mask state shows up at the ports on the very next access. If the current mask is wrong, the software acknowledge reports a different winner or none at all. If the saved mask is wrong, it appears at the next restore, when reading address 0 returns the wrong value. `irq_level` follows the arbitration on the same cycle that a request or mask changes. A stuck or misordered arbiter is therefore caught by the first software acknowledge after the pattern changes, including equal-level ties and level-7 requests that arrive above a saturated mask.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int LVLW = 3;
  typedef logic [LVLW-1:0] lvl_t;
  localparam lvl_t LVL_TOP = 3'd7;

  localparam int REG_CUR     = 0;
  localparam int REG_SAV     = 1;
  localparam int REG_RESTORE = 2;
  localparam int REG_HWACK   = 3;
  localparam int REG_SWACK   = 4;

  localparam int CFG_MSK_BIT = 3;
endpackage

// File: rtl/intc_src_cfg.sv
module intc_src_cfg
  import intc_pkg::*;
#(
  parameter int NSRC = 16,
  parameter int IDXW = $clog2(NSRC)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [IDXW-1:0]     wr_idx,
  input  lvl_t                wr_lvl,
  input  logic                wr_msk,
  output lvl_t [NSRC-1:0]     lvl,
  output logic [NSRC-1:0]     msk
);
  for (genvar g = 0; g < NSRC; g++) begin : g_src
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lvl[g] <= '0;
        msk[g] <= 1'b1;
      end else if (wr_en && wr_idx == IDXW'(g)) begin
        lvl[g] <= wr_lvl;
        msk[g] <= wr_msk;
      end
    end
  end
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter
  import intc_pkg::*;
#(
  parameter int NSRC = 16,
  parameter int IDXW = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]   req,
  input  logic [NSRC-1:0]   msk,
  input  lvl_t [NSRC-1:0]   lvl,
  input  lvl_t              cur,
  output logic              win_vld,
  output logic [IDXW-1:0]   win_idx,
  output lvl_t              win_lvl
);
  logic [NSRC-1:0] elig;

  for (genvar g = 0; g < NSRC; g++) begin : g_elig
    assign elig[g] = req[g] && !msk[g] && (lvl[g] != '0) &&
                     ((lvl[g] > cur) || (lvl[g] == LVL_TOP));
  end

  // Descending scan with >= so that equal levels settle on the lowest index.
  always_comb begin
    win_vld = 1'b0;
    win_idx = '0;
    win_lvl = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (elig[i] && (!win_vld || lvl[i] >= win_lvl)) begin
        win_vld = 1'b1;
        win_idx = IDXW'(i);
        win_lvl = lvl[i];
      end
    end
  end
endmodule

// File: rtl/intc_mask_unit.sv
module intc_mask_unit
  import intc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ack_take,
  input  lvl_t ack_lvl,
  input  logic wr_cur,
  input  logic wr_sav,
  input  logic restore,
  input  lvl_t wdata,
  output lvl_t cur,
  output lvl_t sav
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur <= '0;
      sav <= '0;
    end else if (ack_take) begin
      sav <= cur;
      cur <= ack_lvl;
    end else begin
      if (wr_cur)       cur <= wdata;
      else if (restore) cur <= sav;
      if (wr_sav)       sav <= wdata;
    end
  end
endmodule

// File: rtl/intc_lvl_ack.sv
module intc_lvl_ack
  import intc_pkg::*;
#(
  parameter int NSRC     = 16,
  parameter int DW       = 8,
  parameter int VEC_BASE = 64,
  parameter int SPUR_VEC = 24,
  parameter int ADDRW    = $clog2(NSRC) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   irq_req,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_write,
  input  logic [ADDRW-1:0]  cmd_addr,
  input  logic [DW-1:0]     cmd_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DW-1:0]     rsp_data,
  output logic [LVLW-1:0]   irq_level
);
  localparam int IDXW = $clog2(NSRC);

  lvl_t [NSRC-1:0]  src_lvl;
  logic [NSRC-1:0]  src_msk;
  lvl_t             cur_mask, sav_mask;
  logic             win_vld;
  logic [IDXW-1:0]  win_idx;
  lvl_t             win_lvl;

  logic cmd_fire, is_cfg;
  logic sel_cur, sel_sav, sel_restore, sel_hwack, sel_swack;
  logic [IDXW-1:0] cfg_idx;
  logic [DW-1:0]   vec, rd_data;

  assign cmd_ready = !rsp_valid || rsp_ready;
  assign cmd_fire  = cmd_valid && cmd_ready;

  assign is_cfg      = cmd_addr[ADDRW-1];
  assign cfg_idx     = cmd_addr[IDXW-1:0];
  assign sel_cur     = !is_cfg && cmd_addr == ADDRW'(REG_CUR);
  assign sel_sav     = !is_cfg && cmd_addr == ADDRW'(REG_SAV);
  assign sel_restore = !is_cfg && cmd_addr == ADDRW'(REG_RESTORE);
  assign sel_hwack   = !is_cfg && cmd_addr == ADDRW'(REG_HWACK);
  assign sel_swack   = !is_cfg && cmd_addr == ADDRW'(REG_SWACK);

  intc_src_cfg #(.NSRC(NSRC)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (cmd_fire && cmd_write && is_cfg),
    .wr_idx (cfg_idx),
    .wr_lvl (cmd_wdata[LVLW-1:0]),
    .wr_msk (cmd_wdata[CFG_MSK_BIT]),
    .lvl    (src_lvl),
    .msk    (src_msk)
  );

  intc_arbiter #(.NSRC(NSRC)) u_arb (
    .req     (irq_req),
    .msk     (src_msk),
    .lvl     (src_lvl),
    .cur     (cur_mask),
    .win_vld (win_vld),
    .win_idx (win_idx),
    .win_lvl (win_lvl)
  );

  intc_mask_unit u_mask (
    .clk      (clk),
    .rst_n    (rst_n),
    .ack_take (cmd_fire && !cmd_write && sel_hwack && win_vld),
    .ack_lvl  (win_lvl),
    .wr_cur   (cmd_fire && cmd_write && sel_cur),
    .wr_sav   (cmd_fire && cmd_write && sel_sav),
    .restore  (cmd_fire && cmd_write && sel_restore),
    .wdata    (cmd_wdata[LVLW-1:0]),
    .cur      (cur_mask),
    .sav      (sav_mask)
  );

  assign vec       = DW'(VEC_BASE) + DW'(win_idx);
  assign irq_level = win_lvl;

  always_comb begin
    rd_data = '0;
    if (is_cfg)         rd_data = DW'({src_msk[cfg_idx], src_lvl[cfg_idx]});
    else if (sel_cur)   rd_data = DW'(cur_mask);
    else if (sel_sav)   rd_data = DW'(sav_mask);
    else if (sel_hwack) rd_data = win_vld ? vec : DW'(SPUR_VEC);
    else if (sel_swack) rd_data = win_vld ? vec : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (cmd_fire) begin
      rsp_valid <= 1'b1;
      rsp_data  <= cmd_write ? cmd_wdata : rd_data;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/intc_lvl_ack_chk.sv
module intc_lvl_ack_chk
  import intc_pkg::*;
#(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_fire,
  input logic          cmd_write,
  input logic          sel_hwack,
  input logic          sel_swack,
  input logic          win_vld,
  input lvl_t          win_lvl,
  input lvl_t          cur_mask,
  input lvl_t          sav_mask,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic [DW-1:0] rsp_data
);
  p_ack_saves_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_fire && !cmd_write && sel_hwack && win_vld |=> sav_mask == $past(cur_mask));

  p_ack_raises_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_fire && !cmd_write && sel_hwack && win_vld |=> cur_mask == $past(win_lvl));

  p_spur_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_fire && !cmd_write && sel_hwack && !win_vld |=> $stable(cur_mask) && $stable(sav_mask));

  p_swack_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_fire && !cmd_write && sel_swack |=> $stable(cur_mask) && $stable(sav_mask));

  p_rsp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));
endmodule

bind intc_lvl_ack intc_lvl_ack_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_fire  (cmd_fire),
  .cmd_write (cmd_write),
  .sel_hwack (sel_hwack),
  .sel_swack (sel_swack),
  .win_vld   (win_vld),
  .win_lvl   (win_lvl),
  .cur_mask  (cur_mask),
  .sav_mask  (sav_mask),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_data  (rsp_data)
);

// File: tb/tb_intc_lvl_ack.sv
module tb_intc_lvl_ack;
  localparam int NSRC = 16;
  localparam int A_CUR = 0, A_SAV = 1, A_RST = 2, A_HW = 3, A_SW = 4, A_CFG = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] irq_req = '0;
  logic        cmd_valid = 1'b0, cmd_write = 1'b0, rsp_ready = 1'b1;
  logic [4:0]  cmd_addr = '0;
  logic [7:0]  cmd_wdata = '0;
  logic        cmd_ready, rsp_valid;
  logic [7:0]  rsp_data;
  logic [2:0]  irq_level;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  intc_lvl_ack dut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .irq_level(irq_level)
  );

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic w, input int a, input int d, output logic [7:0] r);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = w; cmd_addr = a[4:0]; cmd_wdata = d[7:0];
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    r = rsp_data;
  endtask

  task automatic wr(input int a, input int d);
    logic [7:0] r;
    xfer(1'b1, a, d, r);
  endtask

  task automatic rd_chk(input int a, input int exp, input string tag);
    logic [7:0] r;
    xfer(1'b0, a, 0, r);
    chk(int'(r), exp, tag);
  endtask

  task automatic cfg(input int src, input int lvl, input int m);
    wr(A_CFG + src, (m << 3) | lvl);
  endtask

  task automatic set_req(input logic [15:0] v);
    @(negedge clk);
    irq_req = v;
  endtask

  task automatic t_reset;
    chk(int'(irq_level), 0, "R11 irq_level");
    rd_chk(A_CUR, 0, "R11 cur");
    rd_chk(A_SAV, 0, "R11 sav");
    rd_chk(A_CFG + 0, 8, "R11 cfg0 R13");
    set_req(16'hFFFF);
    rd_chk(A_SW, 0, "R4 all masked after reset");
    set_req('0);
  endtask

  task automatic t_priority;
    cfg(1, 2, 0); cfg(3, 4, 0); cfg(5, 4, 0); cfg(9, 6, 0);
    cfg(7, 7, 0); cfg(12, 5, 1);
    rd_chk(A_CFG + 12, 13, "R13 cfg readback");
    set_req(16'h0028);
    rd_chk(A_SW, 67, "R5 tie lowest index");
    chk(int'(irq_level), 4, "R12 level");
    set_req(16'h102A);
    rd_chk(A_SW, 67, "R4 masked source skipped");
    set_req(16'h122A);
    rd_chk(A_SW, 73, "R5 highest level");
    chk(int'(irq_level), 6, "R12 level 6");
    set_req(16'h12AA);
    rd_chk(A_SW, 71, "R5 level 7");
  endtask

  task automatic t_nest;
    wr(A_CUR, 0);
    set_req(16'h0208);
    rd_chk(A_HW, 73, "R1 hw vector");
    rd_chk(A_CUR, 6, "R3 cur raised");
    rd_chk(A_SAV, 0, "R2 sav copied");
    rd_chk(A_SW, 0, "R4 held off at/below mask");
    chk(int'(irq_level), 0, "R12 none eligible");
    set_req(16'h0288);
    rd_chk(A_HW, 71, "R1 nested hw vector");
    rd_chk(A_SAV, 6, "R2 nested save");
    rd_chk(A_CUR, 7, "R3 nested raise");
    rd_chk(A_SW, 71, "R4 level 7 unmaskable");
    wr(A_RST, 0);
    rd_chk(A_CUR, 6, "R8 restore");
  endtask

  task automatic t_direct;
    set_req(16'h020A);
    wr(A_CUR, 3);
    rd_chk(A_SW, 73, "R8 direct cur 3");
    set_req(16'h000A);
    rd_chk(A_SW, 67, "R9 dropped request gone");
    wr(A_CUR, 4);
    rd_chk(A_SW, 0, "R4 strict greater");
    wr(A_SAV, 5);
    rd_chk(A_SAV, 5, "R8 sav write");
    rd_chk(A_CUR, 4, "R7 swack left cur");
  endtask

  task automatic t_spurious;
    set_req('0);
    rd_chk(A_HW, 24, "R6 spurious vector");
    rd_chk(A_CUR, 4, "R6 cur unchanged");
    rd_chk(A_SAV, 5, "R6 sav unchanged");
  endtask

  task automatic t_level;
    wr(A_CUR, 0);
    set_req(16'h0008);
    rd_chk(A_SW, 67, "R9 present");
    set_req('0);
    rd_chk(A_SW, 0, "R9 no latched pending");
    rd_chk(A_HW, 24, "R9 hw after drop");
  endtask

  task automatic t_backpressure;
    set_req(16'h0200);
    @(negedge clk);
    rsp_ready = 1'b0;
    cmd_valid = 1'b1; cmd_write = 1'b0; cmd_addr = 5'(A_SW); cmd_wdata = '0;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(int'(rsp_valid), 1, "R10 rsp valid");
    chk(int'(rsp_data), 73, "R10 rsp data");
    irq_req = 16'h0008;
    cmd_valid = 1'b1; cmd_write = 1'b1; cmd_addr = 5'(A_CUR); cmd_wdata = 8'd5;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(int'(cmd_ready), 0, "R10 no accept while held");
      chk(int'(rsp_data), 73, "R10 data stable");
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(int'(rsp_valid), 1, "R10 write response");
    chk(int'(rsp_data), 5, "R10 write echo");
    rd_chk(A_CUR, 5, "R10 stalled write landed");
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_priority();
    t_nest();
    t_direct();
    t_spurious();
    t_level();
    t_backpressure();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule